// File: doc/BRIEF.md
# Movable-Boundary Security Attribution Unit

This block labels every transaction address with one of three security attributes: Secure, Non-secure Callable (NSC) or Non-secure. The address space is cut into equal slots selected by the top address bits. Two slots hold memories whose inner layout can be moved: a first memory split into regions 0, 1 and 2 by two watermark registers, and a second memory split into regions 4, 5 and 6 by two more. Every other slot maps to a fixed region number. Each region has a type bit in one of two 32-bit type words. A set bit makes the region Non-secure. A clear bit leaves it Secure, except for the middle regions 1 and 5, which are then Non-secure Callable.

Software programs the type words and the four watermarks through a simple valid/write-enable register port. Reads on that port return data one cycle later. The lookup port is purely combinational: an address goes in, and a region number and an attribute come out in the same cycle. When a pair of watermarks is out of order, a programming-error output rises, and every address in the affected memory is reported Secure until the order is repaired.

Top module: `mb_sau`

## Requirements
- R1: After a synchronous reset, all type bits, all watermarks and `prog_err` are 0. Every lookup in the first memory then returns region 2 with attribute Secure.
- R2: Register address 0 holds the type bits of regions 0..31 (bit n = region n). Address 1 holds those of regions 32..39 in bits 7:0. Bits of address 1 above bit 7 ignore writes and read 0. Read data appears on `reg_rdata` on the clock edge that accepts the read.
- R3: Addresses 2, 3, 4 and 5 hold the watermarks b01, b12, b45 and b56. Each is a byte offset at 4 kB granularity: only bits 25:12 are stored, and all other bits read 0.
- R4: An address whose bits 31:26 equal 0 belongs to the first memory. Its offset (bits 25:0) maps to region 0 below b01, to region 1 from b01 up to but not including b12, and to region 2 at b12 and above.
- R5: An address whose bits 31:26 equal 8 belongs to the second memory. It maps to regions 4, 5 and 6 in the same way, using b45 and b56.
- R6: The other slots map to fixed regions. Slots 1..7 map to region 3. Slot 9+k maps to region 7+k, up to region 39. Slots 41 and above all map to region 39.
- R7: The attribute is encoded as 2'b00 Secure, 2'b01 NSC and 2'b10 Non-secure. A set type bit gives Non-secure. A clear type bit gives Secure, except for regions 1 and 5, which give NSC.
- R8: When the two watermarks of a memory are equal, that memory's middle region has zero size and is never reported.
- R9: One cycle after a write leaves b12 < b01 or b56 < b45, `prog_err` is 1. It returns to 0 one cycle after a later write restores the order.
- R10: While a memory's watermark pair is out of order, every address in that memory is reported Secure, whatever its type bit. The other memory is not affected.
- R11: Register accesses with `reg_valid` low change nothing. Writes to addresses 6 and 7 change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| prog_err | output | 1 | Watermark ordering error in either memory |
| lk_addr | input | 32 | Lookup address |
| lk_region | output | 6 | Matched region number |
| lk_attr | output | 2 | Security attribute of the lookup |

## Verification
The hardest state to reach is an error confined to one memory while the other memory still reports correctly. To set it up, the bench first programs a valid layout with Non-secure regions in both memories. It then breaks the ordering of one watermark pair by writing a single lower value. Next it probes the broken memory, which must read Secure even where its type bit is set, and the intact memory, which must keep its Non-secure answer. Finally it repairs the pair and repeats the same sequence for the other memory. Zero-size middle regions are reached by writing equal watermarks and probing the address exactly at the shared boundary.

// File: rtl/mbsau_pkg.sv
package mbsau_pkg;
  typedef enum logic [1:0] {
    ATTR_SEC = 2'b00,
    ATTR_NSC = 2'b01,
    ATTR_NS  = 2'b10
  } attr_e;

  localparam logic [2:0] RA_TYPE0 = 3'd0;
  localparam logic [2:0] RA_TYPE1 = 3'd1;
  localparam logic [2:0] RA_B01   = 3'd2;
  localparam logic [2:0] RA_B12   = 3'd3;
  localparam logic [2:0] RA_B45   = 3'd4;
  localparam logic [2:0] RA_B56   = 3'd5;
endpackage

// File: rtl/mbsau_regs.sv
module mbsau_regs
  import mbsau_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_REGIONS = 40,
  parameter int unsigned OFF_W       = 26,
  parameter int unsigned GRAN_W      = 12,
  parameter int unsigned BND_W       = OFF_W - GRAN_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_valid,
  input  logic                        reg_we,
  input  logic [2:0]                  reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output logic [NUM_REGIONS-1:0]      type_bits,
  output logic [3:0][BND_W-1:0]       bnd,
  output logic                        err_a,
  output logic                        err_b
);
  localparam int unsigned TYPE_W = 2 * DATA_W;
  localparam logic [TYPE_W-1:0] TYPE_MASK = TYPE_W'({NUM_REGIONS{1'b1}});

  logic [TYPE_W-1:0]      type_q;
  logic [3:0][BND_W-1:0]  bnd_q, bnd_d;
  logic                   err_a_q, err_b_q;
  logic [DATA_W-1:0]      rd_mux;
  logic                   wr_en, rd_en;

  assign wr_en = reg_valid && reg_we;
  assign rd_en = reg_valid && !reg_we;

  // next watermark values, so the ordering flag tracks the same edge
  always_comb begin
    bnd_d = bnd_q;
    if (wr_en) begin
      for (int i = 0; i < 4; i++) begin
        if (int'(reg_addr) == int'(RA_B01) + i)
          bnd_d[i] = reg_wdata[OFF_W-1:GRAN_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q  <= '0;
      bnd_q   <= '0;
      err_a_q <= 1'b0;
      err_b_q <= 1'b0;
    end else begin
      for (int w = 0; w < 2; w++) begin
        if (wr_en && int'(reg_addr) == int'(RA_TYPE0) + w)
          type_q[w*DATA_W +: DATA_W] <= reg_wdata & TYPE_MASK[w*DATA_W +: DATA_W];
      end
      bnd_q   <= bnd_d;
      err_a_q <= bnd_d[1] < bnd_d[0];
      err_b_q <= bnd_d[3] < bnd_d[2];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_TYPE0: rd_mux = type_q[DATA_W-1:0];
      RA_TYPE1: rd_mux = type_q[TYPE_W-1:DATA_W];
      RA_B01, RA_B12, RA_B45, RA_B56:
        rd_mux[OFF_W-1:GRAN_W] = bnd_q[2'(reg_addr - RA_B01)];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        reg_rdata <= '0;
    else if (rd_en) reg_rdata <= rd_mux;
  end

  assign type_bits = type_q[NUM_REGIONS-1:0];
  assign bnd       = bnd_q;
  assign err_a     = err_a_q;
  assign err_b     = err_b_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (type_q == '0 && bnd_q == '0 && !err_a_q && !err_b_q));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_valid |=> ($stable(type_q) && $stable(bnd_q)));

  // R11
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && !reg_we) |=> ($stable(type_q) && $stable(bnd_q)));

  // R3
  bnd_granule_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(reg_addr) >= RA_B01 && $past(reg_addr) <= RA_B56)
      |-> (reg_rdata[GRAN_W-1:0] == '0));
endmodule

// File: rtl/mbsau_split.sv
module mbsau_split #(
  parameter int unsigned BND_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BND_W-1:0] off_hi,
  input  logic [BND_W-1:0] b_lo,
  input  logic [BND_W-1:0] b_hi,
  output logic [1:0]       sel
);
  always_comb begin
    if (off_hi < b_lo)      sel = 2'd0;
    else if (off_hi < b_hi) sel = 2'd1;
    else                    sel = 2'd2;
  end

  // R8
  zero_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (b_lo == b_hi) |-> (sel != 2'd1));

  // R4
  mid_window_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'd1) |-> (off_hi >= b_lo && off_hi < b_hi));

  // R4
  sel_legal_chk: assert property (@(posedge clk) disable iff (rst)
    sel != 2'd3);
endmodule

// File: rtl/mbsau_fixmap.sv
module mbsau_fixmap #(
  parameter int unsigned SLOT_W      = 6,
  parameter int unsigned NUM_REGIONS = 40,
  parameter int unsigned RIDX_W      = 6,
  parameter int unsigned MEMB_SLOT   = 8
) (
  input  logic [SLOT_W-1:0] slot,
  output logic [RIDX_W-1:0] ridx
);
  localparam int NSLOT       = 1 << SLOT_W;
  localparam int LOW_REGION  = 3;
  localparam int HIGH_FIRST  = 7;
  localparam int LAST_REGION = NUM_REGIONS - 1;

  logic [RIDX_W-1:0] tbl [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int RAW = s - int'(MEMB_SLOT) - 1 + HIGH_FIRST;
    localparam int VAL = (s < int'(MEMB_SLOT)) ? LOW_REGION :
                         ((RAW > LAST_REGION) ? LAST_REGION : RAW);
    assign tbl[s] = RIDX_W'(VAL);
  end

  assign ridx = tbl[slot];
endmodule

// File: rtl/mb_sau.sv
module mb_sau
  import mbsau_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SLOT_W      = 6,
  parameter int unsigned GRAN_W      = 12,
  parameter int unsigned NUM_REGIONS = 40,
  parameter int unsigned MEMA_SLOT   = 0,
  parameter int unsigned MEMB_SLOT   = 8,
  parameter int unsigned RIDX_W      = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              prog_err,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [RIDX_W-1:0] lk_region,
  output logic [1:0]        lk_attr
);
  localparam int unsigned OFF_W = ADDR_W - SLOT_W;
  localparam int unsigned BND_W = OFF_W - GRAN_W;

  logic [NUM_REGIONS-1:0]  type_bits;
  logic [3:0][BND_W-1:0]   bnd;
  logic                    err_a, err_b;
  logic [SLOT_W-1:0]       slot;
  logic [BND_W-1:0]        off_hi;
  logic [1:0]              sel [2];
  logic [RIDX_W-1:0]       fix_ridx;
  logic [RIDX_W-1:0]       region;
  logic                    in_err, in_mem_a, in_mem_b;
  attr_e                   attr;
  logic                    unused_low;

  mbsau_regs #(
    .DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS),
    .OFF_W(OFF_W), .GRAN_W(GRAN_W), .BND_W(BND_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_valid(reg_valid), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .type_bits(type_bits), .bnd(bnd), .err_a(err_a), .err_b(err_b)
  );

  assign slot       = lk_addr[ADDR_W-1 -: SLOT_W];
  assign off_hi     = lk_addr[OFF_W-1:GRAN_W];
  assign unused_low = ^lk_addr[GRAN_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_mem
    mbsau_split #(.BND_W(BND_W)) u_split (
      .clk(clk), .rst(rst), .off_hi(off_hi),
      .b_lo(bnd[2*g]), .b_hi(bnd[2*g+1]), .sel(sel[g])
    );
  end

  mbsau_fixmap #(
    .SLOT_W(SLOT_W), .NUM_REGIONS(NUM_REGIONS),
    .RIDX_W(RIDX_W), .MEMB_SLOT(MEMB_SLOT)
  ) u_fix (
    .slot(slot), .ridx(fix_ridx)
  );

  assign in_mem_a = (slot == SLOT_W'(MEMA_SLOT));
  assign in_mem_b = (slot == SLOT_W'(MEMB_SLOT));

  always_comb begin
    if (in_mem_a) begin
      region = RIDX_W'(sel[0]);
      in_err = err_a;
    end else if (in_mem_b) begin
      region = RIDX_W'(4) + RIDX_W'(sel[1]);
      in_err = err_b;
    end else begin
      region = fix_ridx;
      in_err = 1'b0;
    end
  end

  always_comb begin
    if (in_err)                                    attr = ATTR_SEC;
    else if (type_bits[region])                    attr = ATTR_NS;
    else if (region == RIDX_W'(1) || region == RIDX_W'(5)) attr = ATTR_NSC;
    else                                           attr = ATTR_SEC;
  end

  assign lk_region = region;
  assign lk_attr   = attr;
  assign prog_err  = err_a | err_b;

  // R10
  err_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    ((in_mem_a && err_a) || (in_mem_b && err_b)) |-> (lk_attr == ATTR_SEC));

  // R7
  nsc_region_chk: assert property (@(posedge clk) disable iff (rst)
    (!prog_err && (lk_region == RIDX_W'(1) || lk_region == RIDX_W'(5)))
      |-> (lk_attr != ATTR_SEC));

  // R6
  fixed_range_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_mem_a && !in_mem_b)
      |-> (lk_region == RIDX_W'(3) || lk_region >= RIDX_W'(7)));

  // R9
  order_flag_chk: assert property (@(posedge clk) disable iff (rst)
    prog_err == ((bnd[1] < bnd[0]) || (bnd[3] < bnd[2])));

  // R7
  attr_code_chk: assert property (@(posedge clk) disable iff (rst)
    lk_attr != 2'b11);
endmodule

// File: tb/tb_mb_sau.sv
module tb_mb_sau;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_valid = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        prog_err;
  logic [31:0] lk_addr = '0;
  logic [5:0]  lk_region;
  logic [1:0]  lk_attr;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  localparam logic [1:0] S = 2'b00, C = 2'b01, N = 2'b10;

  // {address, expected region, expected attribute}
  // layout: b01=0x3F000 b12=0x40000 b45=b56=0xB000; NS regions 2,3,6,11,33
  localparam logic [39:0] VEC [16] = '{
    {32'h0000_0000, 6'd0,  S},
    {32'h0003_EFFF, 6'd0,  S},
    {32'h0003_F000, 6'd1,  C},
    {32'h0003_FFFC, 6'd1,  C},
    {32'h0004_0000, 6'd2,  N},
    {32'h03FF_FFFF, 6'd2,  N},
    {32'h0400_0000, 6'd3,  N},
    {32'h1FFF_FFFF, 6'd3,  N},
    {32'h2000_0000, 6'd4,  S},
    {32'h2000_AFFF, 6'd4,  S},
    {32'h2000_B000, 6'd6,  N},
    {32'h2400_0000, 6'd7,  S},
    {32'h3400_0000, 6'd11, N},
    {32'h8C00_0000, 6'd33, N},
    {32'hA400_0000, 6'd39, S},
    {32'hFC00_0000, 6'd39, S}
  };

  mb_sau dut (
    .clk(clk), .rst(rst),
    .reg_valid(reg_valid), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prog_err(prog_err),
    .lk_addr(lk_addr), .lk_region(lk_region), .lk_attr(lk_attr)
  );

  always #2 clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp<=20000", cycles);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic look(string req, logic [31:0] a, logic [5:0] er, logic [1:0] ea);
    @(negedge clk);
    lk_addr = a;
    #1;
    chk(req, {26'd0, lk_region}, {26'd0, er});
    chk(req, {30'd0, lk_attr}, {30'd0, ea});
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reg reset", d, 32'h0);
    end
    chk("R1 prog_err reset", {31'd0, prog_err}, 32'h0);
    look("R1 reset lookup", 32'h0000_0000, 6'd2, S);
    look("R1 reset lookup top", 32'h03FF_F000, 6'd2, S);

    // R2/R3: masking of stored bits
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d);
    chk("R2 type1 mask", d, 32'h0000_00FF);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d);
    chk("R3 b01 mask", d, 32'h03FF_F000);
    wr(3'd0, 32'hA5A5_5A5A);
    rd(3'd0, d);
    chk("R2 type0 full", d, 32'hA5A5_5A5A);

    // R11: inert accesses
    @(negedge clk);
    reg_valid = 1'b0; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0;
    @(negedge clk);
    reg_we = 1'b0;
    rd(3'd0, d);
    chk("R11 valid low write", d, 32'hA5A5_5A5A);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, d);
    chk("R11 unmapped read", d, 32'h0);
    rd(3'd0, d);
    chk("R11 unmapped write no effect", d, 32'hA5A5_5A5A);

    // program the vector layout
    wr(3'd0, 32'h0000_084C);
    wr(3'd1, 32'h0000_0002);
    wr(3'd2, 32'h0003_F000);
    wr(3'd3, 32'h0004_0000);
    wr(3'd4, 32'h0000_B000);
    wr(3'd5, 32'h0000_B000);
    chk("R9 ordered no error", {31'd0, prog_err}, 32'h0);

    // R4 R5 R6 R7 R8: table walk
    for (int i = 0; i < 16; i++)
      look("R4/R5/R6/R7/R8 vector", VEC[i][39:8], VEC[i][7:2], VEC[i][1:0]);

    // R5 R7: open region 5, NSC then NS
    wr(3'd5, 32'h0000_C000);
    look("R5 region5 NSC", 32'h2000_B000, 6'd5, C);
    look("R5 region6 above", 32'h2000_C000, 6'd6, N);
    wr(3'd0, 32'h0000_086C);
    look("R7 region5 NS", 32'h2000_B000, 6'd5, N);

    // R9 R10: break first memory
    wr(3'd3, 32'h0003_E000);
    chk("R9 error set", {31'd0, prog_err}, 32'h1);
    look("R10 mem A fallback", 32'h0004_0000, 6'd2, S);
    look("R10 mem B intact", 32'h2000_C000, 6'd6, N);
    wr(3'd3, 32'h0004_0000);
    chk("R9 error cleared", {31'd0, prog_err}, 32'h0);
    look("R10 mem A restored", 32'h0004_0000, 6'd2, N);

    // R9 R10: break second memory
    wr(3'd5, 32'h0000_A000);
    chk("R9 error set B", {31'd0, prog_err}, 32'h1);
    look("R10 mem B fallback", 32'h2000_C000, 6'd6, S);
    look("R10 mem A intact", 32'h0004_0000, 6'd2, N);
    wr(3'd4, 32'h0000_A000);
    chk("R9 equal pair clears", {31'd0, prog_err}, 32'h0);
    look("R8 equal pair zero size", 32'h2000_A000, 6'd6, N);

    done = 1'b1;
    summary();
  end
endmodule